// File: doc/BRIEF.md
# Moving-Average Sketch Forecaster

This block runs once at the end of each observation interval, after a sketch of counters (rows by columns) has been filled by an upstream update engine. A single start strobe makes it walk the newly completed sketch one counter per cycle through a synchronous read port. For every counter it produces two results: the forecast for the next interval and the forecast error for the interval just closed. The forecast is the moving average of the last `2**WIN_LOG2` observed sketches. The error is the observed value minus the forecast that was published one interval earlier.

The block keeps its own circular history of past sketches and an unscaled running sum per counter. The newest value is added to that sum and, once the history window is full, the value leaving the window is subtracted. While the window is still filling, slots that do not yet exist count as zero. The forecast is the running sum shifted right by `WIN_LOG2`. Both results for a counter leave on a write port together with the counter's index.

Top module: `sk_forecaster`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `busy`, `obs_rd_en` and `out_we` are all low.
- R2: A start sampled high while idle makes `busy` go high at that same edge. During the following N cycles `obs_rd_en` is high and `obs_rd_addr` steps through 0 to N-1, where N = ROWS*COLS. The read port returns the addressed counter one cycle after the address.
- R3: The results for the counter read in cycle c appear with `out_we` high in cycle c+2. Counters are written in ascending `out_addr` order, exactly once each per interval. `busy` falls at the edge that presents the last write.
- R4: A start sampled while `busy` is high is ignored. The current pass keeps its read and write sequence unchanged, and no second pass follows.
- R5: While fewer than W = 2**WIN_LOG2 intervals have been processed, `out_fcst` for a counter is floor(sum of all observed values of that counter so far / W). Intervals that have not happened count as zero.
- R6: `out_err` is a two's complement value of width CW+1. It equals the observed value minus the `out_fcst` published for that counter in the previous interval, and that previous forecast is taken as 0 in the first interval after reset.
- R7: From interval W onward, `out_fcst` is floor(sum of the last W observed values, including the current one / W). Older intervals no longer contribute.
- R8: Counter values at the extremes (all zero, all ones) never overflow the forecast. `out_err` then spans +(2**CW-1) down to -(2**CW-1) and never takes the value -2**CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Interval-end strobe; starts a pass when idle |
| busy | output | 1 | High from the accepted start until the last write |
| obs_rd_en | output | 1 | Read request to the completed observed sketch |
| obs_rd_addr | output | IDXW | Counter index being read (row-major) |
| obs_rd_data | input | CW | Counter value, valid one cycle after its address |
| out_we | output | 1 | Write strobe for forecast and error |
| out_addr | output | IDXW | Counter index of the current write |
| out_fcst | output | CW | Forecast for the next interval |
| out_err | output | CW+1 | Signed error: observed minus previous forecast |

## Verification
The start strobe is driven before a rising edge E0. The bench then counts falling edges after that point. At the k-th falling edge it expects a read of address k-1 for k from 1 to N, a write for counter k-3 for k from 3 to N+2, and `busy` high up to k = N+1. Every falling edge is checked against these values, so both a late result and an early result are caught. Expected forecast and error values come from sums over all intervals the bench has recorded, so they do not depend on a running sum. The bench ends each interval only after the first falling edge at which the block is idle again. Extra start pulses are injected mid-pass and on the final busy cycle to show that the same sequence still completes, with no restart.

// File: rtl/sk_fc_pkg.sv
package sk_fc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_RUN   = 2'd1,
      PH_DRAIN = 2'd2
   } fc_phase_e;

   function automatic int safe_clog2(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction
endpackage

// File: rtl/sk_fc_seq.sv
module sk_fc_seq
   import sk_fc_pkg::*;
#(
   parameter int N_CNT    = 16,
   parameter int WIN_LOG2 = 2,
   localparam int IDXW    = safe_clog2(N_CNT),
   localparam int SLOTW   = (WIN_LOG2 > 0) ? WIN_LOG2 : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             busy,
   output logic             rd_en,
   output logic [IDXW-1:0]  rd_idx,
   output logic             s1_vld,
   output logic [IDXW-1:0]  s1_idx,
   output logic [SLOTW-1:0] slot,
   output logic             full
);
   localparam logic [IDXW-1:0]  IDX_LAST  = IDXW'(N_CNT - 1);
   localparam logic [SLOTW-1:0] SLOT_LAST = SLOTW'((2 ** WIN_LOG2) - 1);

   fc_phase_e        ph;
   logic [IDXW-1:0]  idx;
   logic [SLOTW-1:0] slot_q;
   logic [SLOTW-1:0] slot_nx;
   logic             full_q;

   generate
      if (WIN_LOG2 == 0) begin : g_single_slot
         assign slot_nx = '0;
      end else begin : g_ring
         assign slot_nx = slot_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ph     <= PH_IDLE;
         idx    <= '0;
         s1_vld <= 1'b0;
         s1_idx <= '0;
         slot_q <= '0;
         full_q <= 1'b0;
      end else begin
         s1_vld <= rd_en;
         s1_idx <= idx;
         case (ph)
            PH_IDLE: begin
               idx <= '0;
               if (start) ph <= PH_RUN;
            end
            PH_RUN: begin
               if (idx == IDX_LAST) ph <= PH_DRAIN;
               else                 idx <= idx + 1'b1;
            end
            PH_DRAIN: begin
               ph     <= PH_IDLE;
               slot_q <= slot_nx;
               if (slot_q == SLOT_LAST) full_q <= 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy   = (ph != PH_IDLE);
   assign rd_en  = (ph == PH_RUN);
   assign rd_idx = idx;
   assign slot   = slot_q;
   assign full   = full_q;
endmodule

// File: rtl/sk_fc_store.sv
module sk_fc_store
   import sk_fc_pkg::*;
#(
   parameter int N_CNT    = 16,
   parameter int CW       = 16,
   parameter int WIN_LOG2 = 2,
   localparam int W       = 2 ** WIN_LOG2,
   localparam int IDXW    = safe_clog2(N_CNT),
   localparam int SLOTW   = (WIN_LOG2 > 0) ? WIN_LOG2 : 1,
   localparam int HDEPTH  = W * N_CNT,
   localparam int HW      = safe_clog2(HDEPTH),
   localparam int SW      = CW + WIN_LOG2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDXW-1:0]  idx,
   input  logic [SLOTW-1:0] slot,
   input  logic [CW-1:0]    hist_wdata,
   input  logic [SW-1:0]    sum_wdata,
   output logic [CW-1:0]    hist_rdata,
   output logic [SW-1:0]    sum_rdata
);
   logic [CW-1:0] hist_mem [HDEPTH];
   logic [SW-1:0] sum_mem  [N_CNT];
   logic [HW-1:0] haddr;

   always_comb haddr = HW'(slot) * HW'(N_CNT) + HW'(idx);

   // history slots need no reset: the sequencer's full flag gates their use
   always_ff @(posedge clk) begin
      if (we) hist_mem[haddr] <= hist_wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < N_CNT; k++) sum_mem[k] <= '0;
      end else if (we) begin
         sum_mem[idx] <= sum_wdata;
      end
   end

   assign hist_rdata = hist_mem[haddr];
   assign sum_rdata  = sum_mem[idx];
endmodule

// File: rtl/sk_fc_math.sv
module sk_fc_math #(
   parameter int CW       = 16,
   parameter int WIN_LOG2 = 2,
   localparam int SW      = CW + WIN_LOG2
) (
   input  logic [CW-1:0]        obs,
   input  logic [SW-1:0]        old_sum,
   input  logic [CW-1:0]        old_hist,
   input  logic                 full,
   output logic [SW-1:0]        new_sum,
   output logic [CW-1:0]        fcst_new,
   output logic signed [CW:0]   err
);
   logic [SW:0]   acc;
   logic [CW-1:0] fcst_old;

   always_comb begin
      acc = {1'b0, old_sum} + (SW+1)'(obs);
      if (full) acc = acc - (SW+1)'(old_hist);
      new_sum = acc[SW-1:0];
   end

   generate
      if (WIN_LOG2 == 0) begin : g_no_avg
         assign fcst_old = old_sum;
         assign fcst_new = new_sum;
      end else begin : g_shift_avg
         assign fcst_old = old_sum[SW-1:WIN_LOG2];
         assign fcst_new = new_sum[SW-1:WIN_LOG2];
      end
   endgenerate

   assign err = $signed({1'b0, obs}) - $signed({1'b0, fcst_old});
endmodule

// File: rtl/sk_forecaster.sv
module sk_forecaster
   import sk_fc_pkg::*;
#(
   parameter int CW       = 16,
   parameter int ROWS     = 2,
   parameter int COLS     = 8,
   parameter int WIN_LOG2 = 2,
   localparam int N_CNT   = ROWS * COLS,
   localparam int IDXW    = safe_clog2(N_CNT),
   localparam int SLOTW   = (WIN_LOG2 > 0) ? WIN_LOG2 : 1,
   localparam int SW      = CW + WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic              busy,
   output logic              obs_rd_en,
   output logic [IDXW-1:0]   obs_rd_addr,
   input  logic [CW-1:0]     obs_rd_data,
   output logic              out_we,
   output logic [IDXW-1:0]   out_addr,
   output logic [CW-1:0]     out_fcst,
   output logic [CW:0]       out_err
);
   generate
      if (CW < 1 || CW > 48) begin : g_bad_cw
         $error("sk_forecaster: CW out of range");
      end
      if (ROWS < 1 || COLS < 1) begin : g_bad_shape
         $error("sk_forecaster: sketch needs at least one row and column");
      end
      if (WIN_LOG2 < 0 || WIN_LOG2 > 6) begin : g_bad_win
         $error("sk_forecaster: WIN_LOG2 out of range");
      end
   endgenerate

   logic             s1_vld;
   logic [IDXW-1:0]  s1_idx;
   logic [SLOTW-1:0] slot;
   logic             full;
   logic [CW-1:0]    hist_rdata;
   logic [SW-1:0]    sum_rdata;
   logic [SW-1:0]    sum_next;
   logic [CW-1:0]    fcst_next;
   logic signed [CW:0] err_next;

   sk_fc_seq #(.N_CNT(N_CNT), .WIN_LOG2(WIN_LOG2)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .busy   (busy),
      .rd_en  (obs_rd_en),
      .rd_idx (obs_rd_addr),
      .s1_vld (s1_vld),
      .s1_idx (s1_idx),
      .slot   (slot),
      .full   (full)
   );

   sk_fc_store #(.N_CNT(N_CNT), .CW(CW), .WIN_LOG2(WIN_LOG2)) u_store (
      .clk        (clk),
      .rst        (rst),
      .we         (s1_vld),
      .idx        (s1_idx),
      .slot       (slot),
      .hist_wdata (obs_rd_data),
      .sum_wdata  (sum_next),
      .hist_rdata (hist_rdata),
      .sum_rdata  (sum_rdata)
   );

   sk_fc_math #(.CW(CW), .WIN_LOG2(WIN_LOG2)) u_math (
      .obs      (obs_rd_data),
      .old_sum  (sum_rdata),
      .old_hist (hist_rdata),
      .full     (full),
      .new_sum  (sum_next),
      .fcst_new (fcst_next),
      .err      (err_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_we   <= 1'b0;
         out_addr <= '0;
         out_fcst <= '0;
         out_err  <= '0;
      end else begin
         out_we <= s1_vld;
         if (s1_vld) begin
            out_addr <= s1_idx;
            out_fcst <= fcst_next;
            out_err  <= err_next;
         end
      end
   end
endmodule

// File: rtl/sk_forecaster_chk.sv
module sk_forecaster_chk
   import sk_fc_pkg::*;
#(
   parameter int CW       = 16,
   parameter int ROWS     = 2,
   parameter int COLS     = 8,
   parameter int WIN_LOG2 = 2,
   localparam int N_CNT   = ROWS * COLS,
   localparam int IDXW    = safe_clog2(N_CNT)
) (
   input logic            clk,
   input logic            rst,
   input logic            busy,
   input logic            obs_rd_en,
   input logic [IDXW-1:0] obs_rd_addr,
   input logic            out_we,
   input logic [IDXW-1:0] out_addr,
   input logic [CW:0]     out_err
);
   localparam logic [IDXW-1:0] IDX_LAST = IDXW'(N_CNT - 1);
   localparam logic [CW:0]     ERR_MIN  = {1'b1, {CW{1'b0}}};

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !obs_rd_en);                                              // R1
   AST_RD_START: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (obs_rd_en && obs_rd_addr == '0));                  // R2
   AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
      obs_rd_en |-> (obs_rd_addr <= IDX_LAST));                           // R2
   AST_RD_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (obs_rd_en && $past(obs_rd_en)) |-> (obs_rd_addr == $past(obs_rd_addr) + 1'b1)); // R4
   AST_WE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_we |-> ($past(obs_rd_en, 2) && out_addr == $past(obs_rd_addr, 2)));         // R3
   AST_WE_ORDER: assert property (@(posedge clk) disable iff (rst)
      (out_we && $past(out_we)) |-> (out_addr == $past(out_addr) + 1'b1));           // R3
   AST_ERR_NO_MIN: assert property (@(posedge clk) disable iff (rst)
      out_we |-> (out_err != ERR_MIN));                                   // R8
endmodule

bind sk_forecaster sk_forecaster_chk #(
   .CW(CW), .ROWS(ROWS), .COLS(COLS), .WIN_LOG2(WIN_LOG2)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .busy        (busy),
   .obs_rd_en   (obs_rd_en),
   .obs_rd_addr (obs_rd_addr),
   .out_we      (out_we),
   .out_addr    (out_addr),
   .out_err     (out_err)
);

// File: tb/sk_forecaster_test.sv
module sk_forecaster_test;
   localparam int CW   = 16;
   localparam int ROWS = 2;
   localparam int COLS = 8;
   localparam int WL   = 2;
   localparam int W    = 2 ** WL;
   localparam int N    = ROWS * COLS;
   localparam int IDXW = 4;
   localparam int NINT = 12;
   localparam longint MAXV = (64'd1 << CW) - 1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            start = 1'b0;
   logic            busy;
   logic            obs_rd_en;
   logic [IDXW-1:0] obs_rd_addr;
   logic [CW-1:0]   obs_rd_data;
   logic            out_we;
   logic [IDXW-1:0] out_addr;
   logic [CW-1:0]   out_fcst;
   logic [CW:0]     out_err;

   logic [CW-1:0] obs_mem [N];
   longint        obs_all [NINT][N];
   int            n_pass = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) obs_rd_data <= obs_mem[obs_rd_addr];

   sk_forecaster #(.CW(CW), .ROWS(ROWS), .COLS(COLS), .WIN_LOG2(WL)) uut (
      .clk(clk), .rst(rst), .start(start), .busy(busy),
      .obs_rd_en(obs_rd_en), .obs_rd_addr(obs_rd_addr), .obs_rd_data(obs_rd_data),
      .out_we(out_we), .out_addr(out_addr), .out_fcst(out_fcst), .out_err(out_err)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      if (ok) n_pass++;
      else begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic longint pat(input int t, input int i);
      case (t)
         0, 4, 5, 6, 7: return MAXV;
         1, 8:          return 0;
         default:       return longint'((i * 4111 + t * 977 + (i ^ t) * 31) % 65536);
      endcase
   endfunction

   function automatic longint exp_fcst(input int t, input int i);
      longint s = 0;
      int lo = (t - W + 1 < 0) ? 0 : t - W + 1;
      for (int k = lo; k <= t; k++) s += obs_all[k][i];
      return s / W;
   endfunction

   task automatic run_interval(input int t, input bit inject);
      string ttag;
      string ftag;
      longint ef, ee;
      for (int i = 0; i < N; i++) begin
         obs_all[t][i] = pat(t, i);
         obs_mem[i]    = CW'(obs_all[t][i]);
      end
      ttag = inject ? "R4" : "R3";
      if (t == 0 || t == 7 || t == 8) ftag = "R8";
      else if (t < W)                 ftag = "R5";
      else                            ftag = "R7";
      start = 1'b1;
      for (int k = 1; k <= N + 4; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (inject && (k == 5 || k == N + 1)) start = 1'b1;
         if (inject && (k == 6 || k == N + 2)) start = 1'b0;
         chk(busy == (k <= N + 1), ttag, "busy", busy, (k <= N + 1));
         chk(obs_rd_en == (k <= N), "R2", "obs_rd_en", obs_rd_en, (k <= N));
         if (k <= N)
            chk(obs_rd_addr == IDXW'(k - 1), "R2", "obs_rd_addr", obs_rd_addr, k - 1);
         chk(out_we == (k >= 3 && k <= N + 2), ttag, "out_we", out_we, (k >= 3 && k <= N + 2));
         if (out_we && k >= 3 && k <= N + 2) begin
            chk(out_addr == IDXW'(k - 3), ttag, "out_addr", out_addr, k - 3);
            ef = exp_fcst(t, k - 3);
            ee = obs_all[t][k - 3] - ((t == 0) ? 0 : exp_fcst(t - 1, k - 3));
            chk(longint'(out_fcst) == ef, ftag, "out_fcst", out_fcst, ef);
            chk(longint'($signed(out_err)) == ee, (ftag == "R8") ? "R8" : "R6",
                "out_err", $signed(out_err), ee);
         end
      end
   endtask

   initial begin
      for (int i = 0; i < N; i++) obs_mem[i] = '0;
      repeat (4) @(negedge clk);
      chk(!busy && !obs_rd_en && !out_we, "R1", "idle during reset", busy, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy, "R1", "busy after reset", busy, 0);
      chk(!obs_rd_en, "R1", "obs_rd_en after reset", obs_rd_en, 0);
      chk(!out_we, "R1", "out_we after reset", out_we, 0);
      for (int t = 0; t < NINT; t++) begin
         run_interval(t, (t == 2 || t == 9));
         repeat (2) @(negedge clk);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
         $finish;
      end
   end
endmodule